// File: doc/BRIEF.md
# Enable-Latched Static Memory, 1024 x 4

This block is a word-addressed static memory of 1024 entries, each 4 bits wide. It suits a bus master that presents an address and then strobes an active-low chip enable. The block does not use the address pins combinationally. It captures them into an internal register on the first clock edge that sees the enable low after it was high. That captured address then governs the whole access, so the address pins may change freely once the capture has happened.

While the enable stays low, the level of the active-low write enable picks the direction. With write enable low, every clock edge stores the data input at the captured address. The word left behind is the value present at the last edge before write enable rises. With write enable high, the stored word is presented on the data output and the output-enable flag is raised. That flag stands in for the drive of a tri-state pin. Whenever the chip enable is high or a write is in progress, the flag is low and the output is zero.

The bits sit in a 64 x 64 matrix. A one-hot row decoder picks one of 64 rows. A column selector then picks one column inside each of four 16-column groups, and each group holds one data bit. Contents persist indefinitely without refresh.

Top module: `edsram_top`

## Requirements
- R1: While reset is asserted and after it is released with chip enable high, the output-enable flag is 0 and the data output is 0.
- R2: The address is captured on the first rising clock edge at which chip enable is sampled low after having been sampled high. Later changes of the address pins during that same enable-low period have no effect on the word read or written.
- R3: Address bits [9:4] select one of 64 rows, and bits [3:0] select the column inside each group. Data bit b is stored at matrix column b*16 + addr[3:0]. All 1024 addresses hold independent words, so a write never disturbs another address.
- R4: At every rising clock edge after the capture edge, if chip enable and write enable are both low, the data input is stored at the captured address. The value stored last before write enable rises is the one that remains.
- R5: Whenever chip enable is high, the output-enable flag is 0 and the data output is 0, in the same cycle in which chip enable rises.
- R6: Whenever write enable is low, the output-enable flag is 0.
- R7: From the capture edge onward, while chip enable is low and write enable is high, the flag is 1 and the output equals the stored word at the captured address. Between the enable falling and the capture edge the flag is 0.
- R8: Write enable driven low while chip enable is high stores nothing.
- R9: Stored words persist across idle periods and across writes to other addresses, without any refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for enable detection, capture and writes |
| rst_n | input | 1 | Active-low asynchronous reset of the control state |
| ce_n | input | 1 | Active-low chip enable; its falling level starts an access |
| we_n | input | 1 | Active-low write enable |
| addr | input | 10 | Word address, captured at the start of an access |
| din | input | 4 | Write data |
| dout | output | 4 | Read data; zero when not driving |
| dout_en | output | 1 | High when the output would be driven |

## Verification
The bench builds the block with its default parameters: 6 row bits, 4 column bits inside a group, and 4 data bits. That gives the full 1024 x 4 array, so the bench can reach every one of the 64 rows and every one of the 16 column positions in all four bit groups. It can also write all sixteen neighbours in one row to check that they do not disturb each other. At this size an address change after capture can also land in a different row, which exposes any leak of the live address pins into the read path.

// File: rtl/sram_pkg.sv
package sram_pkg;

    localparam int PKG_ROW_BITS = 6;
    localparam int PKG_GRP_BITS = 4;
    localparam int PKG_DATA_W   = 4;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_SETUP = 2'd1,
        ACC_READ  = 2'd2,
        ACC_WRITE = 2'd3
    } acc_e;

    function automatic acc_e acc_decode(input logic act, input logic ce_n, input logic we_n);
        acc_e k;
        if (ce_n)
            k = ACC_IDLE;
        else if (!act)
            k = ACC_SETUP;
        else if (we_n)
            k = ACC_READ;
        else
            k = ACC_WRITE;
        return k;
    endfunction

endpackage

// File: rtl/lat_addr_reg.sv
module lat_addr_reg #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              act_o,
    output logic [ADDR_W-1:0] addr_o
);

    typedef struct packed {
        logic              ce_q;
        logic              act_q;
        logic [ADDR_W-1:0] addr_q;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.ce_q = ce_n;
        if (ce_n) begin
            s_d.act_q = 1'b0;
        end else if (s_q.ce_q) begin
            s_d.act_q  = 1'b1;
            s_d.addr_q = addr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ce_q: 1'b1, act_q: 1'b0, addr_q: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign act_o  = s_q.act_q;
    assign addr_o = s_q.addr_q;

    AST_LATCH_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ce_q && !ce_n) |=> (act_o && addr_o == $past(addr_i))); // R2

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (act_o && !ce_n) |=> $stable(addr_o)); // R2

    AST_IDLE_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !act_o); // R5

endmodule

// File: rtl/row_dec.sv
module row_dec #(
    parameter int ROW_BITS = 6,
    localparam int ROWS    = 1 << ROW_BITS
) (
    input  logic                en_i,
    input  logic [ROW_BITS-1:0] row_i,
    output logic [ROWS-1:0]     sel_o
);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign sel_o[r] = en_i && (row_i == ROW_BITS'(r));
    end

endmodule

// File: rtl/col_grp.sv
module col_grp #(
    parameter int GRP_BITS = 4,
    parameter int DATA_W   = 4,
    localparam int GRP     = 1 << GRP_BITS,
    localparam int COLS    = DATA_W * GRP
) (
    input  logic [GRP_BITS-1:0] col_i,
    input  logic [DATA_W-1:0]   din_i,
    input  logic [COLS-1:0]     word_i,
    output logic [DATA_W-1:0]   rd_o,
    output logic [COLS-1:0]     mask_o,
    output logic [COLS-1:0]     wdat_o
);

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        logic [GRP-1:0] grp_w;
        assign grp_w   = word_i[b*GRP +: GRP];
        assign rd_o[b] = grp_w[col_i];
        for (genvar c = 0; c < GRP; c++) begin : g_col
            assign mask_o[b*GRP + c] = (col_i == GRP_BITS'(c));
            assign wdat_o[b*GRP + c] = din_i[b];
        end
    end

endmodule

// File: rtl/bit_matrix.sv
module bit_matrix #(
    parameter int ROW_BITS = 6,
    parameter int COLS     = 64,
    localparam int ROWS    = 1 << ROW_BITS
) (
    input  logic                clk,
    input  logic [ROWS-1:0]     row_we_i,
    input  logic [ROW_BITS-1:0] rd_row_i,
    input  logic [COLS-1:0]     mask_i,
    input  logic [COLS-1:0]     wdat_i,
    output logic [COLS-1:0]     rword_o
);

    logic [COLS-1:0] mem_q [ROWS];
    logic [COLS-1:0] mem_d [ROWS];

    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            if (row_we_i[r])
                mem_d[r] = (mem_q[r] & ~mask_i) | (wdat_i & mask_i);
            else
                mem_d[r] = mem_q[r];
        end
    end

    always_ff @(posedge clk) begin
        for (int r = 0; r < ROWS; r++) begin
            mem_q[r] <= mem_d[r];
        end
    end

    assign rword_o = mem_q[rd_row_i];

endmodule

// File: rtl/edsram_top.sv
module edsram_top
    import sram_pkg::*;
#(
    parameter int ROW_BITS = PKG_ROW_BITS,
    parameter int GRP_BITS = PKG_GRP_BITS,
    parameter int DATA_W   = PKG_DATA_W,
    localparam int ADDR_W  = ROW_BITS + GRP_BITS,
    localparam int ROWS    = 1 << ROW_BITS,
    localparam int COLS    = DATA_W * (1 << GRP_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    logic              act;
    logic [ADDR_W-1:0] addr_l;
    acc_e              acc;
    logic              wr_go;
    logic [ROWS-1:0]   row_we;
    logic [COLS-1:0]   rword;
    logic [COLS-1:0]   mask;
    logic [COLS-1:0]   wdat;
    logic [DATA_W-1:0] rd;

    lat_addr_reg #(.ADDR_W(ADDR_W)) u_lat (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n   (ce_n),
        .addr_i (addr),
        .act_o  (act),
        .addr_o (addr_l)
    );

    assign acc     = acc_decode(act, ce_n, we_n);
    assign wr_go   = (acc == ACC_WRITE);
    assign dout_en = (acc == ACC_READ);
    assign dout    = dout_en ? rd : '0;

    row_dec #(.ROW_BITS(ROW_BITS)) u_row (
        .en_i  (wr_go),
        .row_i (addr_l[ADDR_W-1 -: ROW_BITS]),
        .sel_o (row_we)
    );

    col_grp #(.GRP_BITS(GRP_BITS), .DATA_W(DATA_W)) u_col (
        .col_i  (addr_l[GRP_BITS-1:0]),
        .din_i  (din),
        .word_i (rword),
        .rd_o   (rd),
        .mask_o (mask),
        .wdat_o (wdat)
    );

    bit_matrix #(.ROW_BITS(ROW_BITS), .COLS(COLS)) u_mat (
        .clk      (clk),
        .row_we_i (row_we),
        .rd_row_i (addr_l[ADDR_W-1 -: ROW_BITS]),
        .mask_i   (mask),
        .wdat_i   (wdat),
        .rword_o  (rword)
    );

    AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> (row_we == '0)); // R8

    AST_ONE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_we)); // R3

    AST_OE_CE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> (!dout_en && dout == '0)); // R5

    AST_OE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !dout_en); // R6

    AST_WRITE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (|row_we) |-> (act && !ce_n && !we_n)); // R4

endmodule

// File: tb/sim_edsram_top.sv
module sim_edsram_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1;
    logic       we_n = 1'b1;
    logic [9:0] addr = '0;
    logic [3:0] din = '0;
    logic [3:0] dout;
    logic       dout_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [3:0] ref_mem [1024];
    bit         ref_ok  [1024];

    typedef struct {
        logic [3:0] data;
        logic       en;
        string      tag;
    } exp_t;
    exp_t exp_q [$];
    event smp_ev;

    always #10 clk = ~clk;

    edsram_top u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    task automatic check(input bit ok, input string tag, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(smp_ev);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(dout_en === e.en && dout === e.data, e.tag,
                      {dout_en, dout}, {e.en, e.data});
            end
        end
    end

    task automatic expect_out(input logic [3:0] d, input logic en, input string tag);
        exp_t e;
        e.data = d; e.en = en; e.tag = tag;
        exp_q.push_back(e);
        ->smp_ev;
        #1;
    endtask

    task automatic wr(input logic [9:0] a, input logic [3:0] d);
        @(negedge clk); ce_n = 1'b0; we_n = 1'b1; addr = a;
        @(negedge clk); we_n = 1'b0; din = d;
        #1 expect_out(4'h0, 1'b0, "R6 output off during write");
        @(negedge clk); we_n = 1'b1; ce_n = 1'b1; addr = ~a;
        ref_mem[a] = d; ref_ok[a] = 1'b1;
    endtask

    task automatic rd(input logic [9:0] a, input bit scramble, input string tag);
        @(negedge clk); ce_n = 1'b0; we_n = 1'b1; addr = a;
        #1 expect_out(4'h0, 1'b0, "R7 off before capture edge");
        @(negedge clk);
        if (scramble) addr = a ^ 10'h3A5;
        #1 expect_out(ref_mem[a], 1'b1, tag);
        @(negedge clk); ce_n = 1'b1;
        #1 expect_out(4'h0, 1'b0, "R5 off while enable high");
    endtask

    function automatic logic [3:0] pat(input logic [9:0] a);
        return a[3:0] ^ a[7:4] ^ {a[9:8], a[9:8]} ^ 4'h5;
    endfunction

    initial begin
        for (int i = 0; i < 1024; i++) begin ref_mem[i] = 'x; ref_ok[i] = 1'b0; end
        #5 check(dout_en === 1'b0 && dout === 4'h0, "R1 in reset", {dout_en, dout}, 5'h00);
        #40 rst_n = 1'b1;
        @(negedge clk);
        check(dout_en === 1'b0 && dout === 4'h0, "R1 after reset", {dout_en, dout}, 5'h00);

        // R3: one address in every row, then every column position
        for (int r = 0; r < 64; r++) wr({r[5:0], r[3:0]}, pat({r[5:0], r[3:0]}));
        for (int c = 0; c < 16; c++) wr({c[5:0] + 6'd7, c[3:0]}, pat({c[5:0] + 6'd7, c[3:0]}) ^ 4'hF);
        // R3: all sixteen neighbours in one row
        for (int c = 0; c < 16; c++) wr({6'd42, c[3:0]}, 4'(c * 3 + 1));
        for (int r = 0; r < 64; r++) rd({r[5:0], r[3:0]}, 1'b0, "R3 row readback");
        for (int c = 0; c < 16; c++) rd({c[5:0] + 6'd7, c[3:0]}, 1'b0, "R3 column readback");
        for (int c = 0; c < 16; c++) rd({6'd42, c[3:0]}, 1'b0, "R3 neighbour readback");

        // R2: address pins change after capture
        rd({6'd42, 4'd5}, 1'b1, "R2 address held after capture");
        rd({6'd3, 4'd3}, 1'b1, "R2 address held after capture");

        // R4: two data values while write enable low, last one stays
        @(negedge clk); ce_n = 1'b0; we_n = 1'b1; addr = 10'h155;
        @(negedge clk); we_n = 1'b0; din = 4'h9; addr = 10'h000;
        @(negedge clk); din = 4'h6;
        @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
        ref_mem[10'h155] = 4'h6;
        rd(10'h155, 1'b0, "R4 last data before write enable rises");
        rd(10'h000, 1'b0, "R2 write ignores later address pins");

        // R8: write enable low with chip enable high
        @(negedge clk); ce_n = 1'b1; we_n = 1'b0; addr = 10'h155; din = 4'h0;
        repeat (3) begin
            @(negedge clk);
            #1 expect_out(4'h0, 1'b0, "R8 no drive, enable high");
        end
        we_n = 1'b1;
        rd(10'h155, 1'b0, "R8 word unchanged after ignored write");

        // R7/R6: read and write in one long enable-low period
        @(negedge clk); ce_n = 1'b0; we_n = 1'b1; addr = 10'h2A7;
        @(negedge clk);
        #1 expect_out(ref_mem[10'h2A7], 1'b1, "R7 read in long cycle");
        we_n = 1'b0; din = 4'hC;
        #1 expect_out(4'h0, 1'b0, "R6 off as write enable falls");
        @(negedge clk); we_n = 1'b1;
        #1 expect_out(4'hC, 1'b1, "R7 read after write same cycle");
        @(negedge clk); ce_n = 1'b1;
        ref_mem[10'h2A7] = 4'hC;

        // R9: idle period, then re-read earlier words
        repeat (50) @(negedge clk);
        rd({6'd0, 4'd0}, 1'b0, "R9 retained");
        rd({6'd63, 4'd15}, 1'b0, "R9 retained");
        rd({6'd42, 4'd0}, 1'b0, "R9 retained");
        rd({6'd42, 4'd15}, 1'b0, "R9 retained");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule